// File: doc/BRIEF.md
# Time-Space Circuit Switch with Per-Line Slot Interchangers

This block switches constant-rate samples between multiplexed trunks. Every input line carries SLOTS samples per frame. Each line feeds its own slot interchanger. The interchanger holds a whole frame of samples and replays them in the next frame, in an order set by a per-line read map. The replayed samples then enter a LINES x LINES crossbar. For every time slot, the crossbar has its own setting: one source line and one enable bit per output line.

With two lines of two slots, any four-endpoint connection pattern can be built from 4 crosspoints instead of 16. The interchanger memory runs at only twice the link rate. An outside agent computes the schedule, which is a perfect matching of sessions onto slots. It writes the schedule through a load port into shadow tables. The switch adopts the shadow tables at the next frame strobe.

A circuit switch cannot hold samples back. Each line therefore moves one sample on every clock, and there is no valid/ready handshake and no back-pressure. The frame strobe marks slot 0 of a frame on every line, and each following clock is the next slot.

Top module: `tst_switch`

## Requirements
- R1: After reset every output line is zero and `out_frm` is low. Both table sets and both interchanger banks are clear, so outputs stay zero until a schedule is loaded.
- R2: A sample that enters line l in slot a of one frame reaches the crossbar during slot b of the next frame, for every slot b whose read-map entry for line l equals a. Read-map `ld_data` bits [SW-1:0] hold the source slot a.
- R3: In slot b, an enabled output o carries the interchanger output of the line named by its select field. For crossbar loads, `ld_data` bit LW is the enable and bits [LW-1:0] are the source line.
- R4: An output whose crossbar entry for the current slot is disabled, or whose select field names a line that does not exist, drives zero.
- R5: Outputs are registered. The value for slot b appears one clock after slot b, and `out_frm` repeats `frm_i` one clock later.
- R6: A load (`ld_en`) writes only the shadow entry addressed by `ld_tgt` (0 = crossbar, 1 = read map), `ld_slot` and `ld_port`. The shadow tables become active in the cycle in which `frm_i` is high. A load made in that same cycle takes effect only at the strobe after it.
- R7: Two or more outputs may select the same line in the same slot, which gives multicast.
- R8: `frm_i` forces the current slot to 0 at any time. Without it, the slot count wraps from SLOTS-1 back to 0. Each strobe also swaps the interchanger write and read banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frm_i | input | 1 | High during slot 0 of a frame |
| din | input | LINES*DW | Input samples, line l at bits [l*DW +: DW] |
| ld_en | input | 1 | Write one shadow table entry |
| ld_tgt | input | 1 | 0 = crossbar table, 1 = read-map table |
| ld_slot | input | SW | Slot of the entry |
| ld_port | input | LW | Output line (crossbar) or input line (map) |
| ld_data | input | CW | Entry value, see R3 and R2 |
| dout | output | LINES*DW | Output samples, line o at bits [o*DW +: DW] |
| out_frm | output | 1 | Frame mark aligned with `dout` |

## Verification
The bench builds the switch with two lines, two slots and 8-bit samples. At that size every crossbar setting (256 enable/select combinations over both slots and both outputs) can be crossed with every read map (16 combinations). The sweep therefore covers every permutation, multicast pattern and disabled output in the 2x2 case. The loads run while frames are passing, so they also land on strobe cycles and take effect part-way through a sequence. A final stretch with irregular strobes and random loads exercises early frame restarts and the bank swaps that go with them.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic {
    LD_XBAR = 1'b0,
    LD_TSI  = 1'b1
  } ld_tgt_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tst_cfg_bank.sv
module tst_cfg_bank #(
  parameter int ENTRIES = 4,
  parameter int EW      = 2,
  localparam int IW     = tst_pkg::idx_w(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IW-1:0]                 wr_idx,
  input  logic [EW-1:0]                 wr_data,
  input  logic                          commit,
  output logic [ENTRIES-1:0][EW-1:0]    eff
);
  logic [ENTRIES-1:0][EW-1:0] shadow_q, active_q;

  // the strobe cycle already runs on the new tables
  assign eff = commit ? shadow_q : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (commit) active_q <= shadow_q;
      if (wr_en && int'(wr_idx) < ENTRIES) shadow_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/tst_tsi.sv
module tst_tsi #(
  parameter int SLOTS = 2,
  parameter int DW    = 8,
  localparam int SW   = tst_pkg::idx_w(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm,
  input  logic [SW-1:0] slot,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] rd_slot,
  output logic [DW-1:0] dout
);
  logic [1:0][SLOTS-1:0][DW-1:0] mem_q;
  logic wb_q, wb_cur;

  assign wb_cur = frm ? ~wb_q : wb_q;
  assign dout   = (int'(rd_slot) < SLOTS) ? mem_q[~wb_cur][rd_slot] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_q <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < SLOTS; s++) mem_q[b][s] <= '0;
    end else begin
      wb_q <= wb_cur;
      if (int'(slot) < SLOTS) mem_q[wb_cur][slot] <= din;
    end
  end
endmodule

// File: rtl/tst_space.sv
module tst_space #(
  parameter int LINES = 2,
  parameter int DW    = 8,
  localparam int LW   = tst_pkg::idx_w(LINES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LINES-1:0][DW-1:0]     in_data,
  input  logic [LINES-1:0][LW-1:0]     sel,
  input  logic [LINES-1:0]             en,
  input  logic                         frm_in,
  output logic [LINES-1:0][DW-1:0]     out_data,
  output logic                         out_frm
);
  for (genvar o = 0; o < LINES; o++) begin : g_xp
    always_ff @(posedge clk) begin
      if (rst)                                  out_data[o] <= '0;
      else if (en[o] && int'(sel[o]) < LINES)   out_data[o] <= in_data[sel[o]];
      else                                      out_data[o] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_frm <= 1'b0;
    else     out_frm <= frm_in;
  end
endmodule

// File: rtl/tst_switch.sv
module tst_switch #(
  parameter int LINES = 2,
  parameter int SLOTS = 2,
  parameter int DW    = 8,
  localparam int LW   = tst_pkg::idx_w(LINES),
  localparam int SW   = tst_pkg::idx_w(SLOTS),
  localparam int CW   = (LW + 1 > SW) ? LW + 1 : SW,
  localparam int NE   = SLOTS * LINES,
  localparam int IW   = tst_pkg::idx_w(NE)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frm_i,
  input  logic [LINES*DW-1:0]   din,
  input  logic                  ld_en,
  input  logic                  ld_tgt,
  input  logic [SW-1:0]         ld_slot,
  input  logic [LW-1:0]         ld_port,
  input  logic [CW-1:0]         ld_data,
  output logic [LINES*DW-1:0]   dout,
  output logic                  out_frm
);
  import tst_pkg::*;

  logic [SW-1:0] slot_q, cur_slot;
  logic [IW-1:0] wr_idx;
  ld_tgt_e       tgt;
  logic [NE-1:0][LW:0]   xb_eff;
  logic [NE-1:0][SW-1:0] map_eff;
  logic [LINES-1:0][SW-1:0] rd_slot;
  logic [LINES-1:0][LW-1:0] cur_sel;
  logic [LINES-1:0]         cur_en;
  logic [LINES-1:0][DW-1:0] tsi_out, sp_out;

  assign tgt      = ld_tgt_e'(ld_tgt);
  assign cur_slot = frm_i ? '0 : slot_q;
  assign wr_idx   = IW'(int'(ld_slot) * LINES + int'(ld_port));

  always_ff @(posedge clk) begin
    if (rst)                              slot_q <= '0;
    else if (cur_slot == SW'(SLOTS - 1))  slot_q <= '0;
    else                                  slot_q <= cur_slot + 1'b1;
  end

  tst_cfg_bank #(.ENTRIES(NE), .EW(LW + 1)) u_xb_cfg (
    .clk(clk), .rst(rst), .wr_en(ld_en && tgt == LD_XBAR), .wr_idx(wr_idx),
    .wr_data(ld_data[LW:0]), .commit(frm_i), .eff(xb_eff)
  );

  tst_cfg_bank #(.ENTRIES(NE), .EW(SW)) u_map_cfg (
    .clk(clk), .rst(rst), .wr_en(ld_en && tgt == LD_TSI), .wr_idx(wr_idx),
    .wr_data(ld_data[SW-1:0]), .commit(frm_i), .eff(map_eff)
  );

  always_comb begin
    for (int p = 0; p < LINES; p++) begin
      rd_slot[p] = map_eff[int'(cur_slot) * LINES + p];
      cur_en[p]  = xb_eff[int'(cur_slot) * LINES + p][LW];
      cur_sel[p] = xb_eff[int'(cur_slot) * LINES + p][LW-1:0];
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    tst_tsi #(.SLOTS(SLOTS), .DW(DW)) u_tsi (
      .clk(clk), .rst(rst), .frm(frm_i), .slot(cur_slot),
      .din(din[l*DW +: DW]), .rd_slot(rd_slot[l]), .dout(tsi_out[l])
    );
    assign dout[l*DW +: DW] = sp_out[l];
  end

  tst_space #(.LINES(LINES), .DW(DW)) u_space (
    .clk(clk), .rst(rst), .in_data(tsi_out), .sel(cur_sel), .en(cur_en),
    .frm_in(frm_i), .out_data(sp_out), .out_frm(out_frm)
  );
endmodule

// File: rtl/tst_switch_chk.sv
module tst_switch_chk #(
  parameter int LINES = 2,
  parameter int SLOTS = 2,
  parameter int DW    = 8,
  localparam int LW   = tst_pkg::idx_w(LINES),
  localparam int SW   = tst_pkg::idx_w(SLOTS)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     frm_i,
  input logic [SW-1:0]            slot_q,
  input logic [LINES-1:0]         cur_en,
  input logic [LINES-1:0][LW-1:0] cur_sel,
  input logic [LINES-1:0][DW-1:0] tsi_out,
  input logic [LINES*DW-1:0]      dout,
  input logic                     out_frm
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0 && !out_frm));

  p_frame_echo_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_frm == $past(frm_i));

  p_slot_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(frm_i)) |-> slot_q == SW'(1 % SLOTS));

  for (genvar o = 0; o < LINES; o++) begin : g_out
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cur_en[o])) |-> dout[o*DW +: DW] == '0);

    // R3 and R7: every enabled output follows its selected line, shared or not
    p_route_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cur_en[o]) && (int'($past(cur_sel[o])) < LINES))
        |-> dout[o*DW +: DW] == $past(tsi_out[cur_sel[o]]));
  end
endmodule

bind tst_switch tst_switch_chk #(.LINES(LINES), .SLOTS(SLOTS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .frm_i(frm_i), .slot_q(slot_q), .cur_en(cur_en),
  .cur_sel(cur_sel), .tsi_out(tsi_out), .dout(dout), .out_frm(out_frm)
);

// File: tb/tst_switch_tb.sv
module tst_switch_tb;
  localparam int LINES = 2, SLOTS = 2, DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, frm_i, ld_en, ld_tgt;
  logic [LINES*DW-1:0] din, dout;
  logic [0:0] ld_slot, ld_port;
  logic [1:0] ld_data;
  logic out_frm;

  int n_cmp = 0, n_bad = 0;

  // reference state, built from the requirements
  int sh_en[2][2], sh_sel[2][2], ac_en[2][2], ac_sel[2][2]; // [slot][out]
  int sh_map[2][2], ac_map[2][2];                          // [line][slot]
  logic [7:0] mb[2][2][2];                                 // [bank][line][slot]
  int wbm, slotm, frame_no;
  int lcg = 12345;

  tst_switch #(.LINES(LINES), .SLOTS(SLOTS), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .frm_i(frm_i), .din(din), .ld_en(ld_en),
    .ld_tgt(ld_tgt), .ld_slot(ld_slot), .ld_port(ld_port), .ld_data(ld_data),
    .dout(dout), .out_frm(out_frm)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        sh_en[a][b] = 0; sh_sel[a][b] = 0; ac_en[a][b] = 0; ac_sel[a][b] = 0;
        sh_map[a][b] = 0; ac_map[a][b] = 0;
        mb[0][a][b] = '0; mb[1][a][b] = '0;
      end
    wbm = 0; slotm = 0; frame_no = 0;
  endtask

  // one slot: drive, predict, compare after the edge
  task automatic cyc(input bit f, input bit le, input bit lt, input int ls,
                     input int lp, input int ldv);
    int s;
    int e_en[2][2], e_sel[2][2], e_map[2][2];
    logic [7:0] d[2];
    logic [7:0] exp_o[2];
    @(negedge clk);
    s = f ? 0 : slotm;                       // R8
    if (f) frame_no++;
    for (int l = 0; l < 2; l++) d[l] = 8'((frame_no * 4 + l * 2 + s) % 127 + 1);
    frm_i = f; din = {d[1], d[0]};
    ld_en = le; ld_tgt = lt; ld_slot = 1'(ls); ld_port = 1'(lp); ld_data = 2'(ldv);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        e_en[a][b]  = f ? sh_en[a][b]  : ac_en[a][b];   // R6
        e_sel[a][b] = f ? sh_sel[a][b] : ac_sel[a][b];
        e_map[a][b] = f ? sh_map[a][b] : ac_map[a][b];
      end
    if (f) wbm ^= 1;                         // R8 bank swap
    for (int o = 0; o < 2; o++)              // R2 / R3 / R4 / R7
      exp_o[o] = e_en[s][o] ? mb[wbm ^ 1][e_sel[s][o]][e_map[e_sel[s][o]][s]] : 8'h00;
    for (int l = 0; l < 2; l++) mb[wbm][l][s] = d[l];
    if (f) begin
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          ac_en[a][b] = sh_en[a][b]; ac_sel[a][b] = sh_sel[a][b]; ac_map[a][b] = sh_map[a][b];
        end
    end
    if (le) begin                            // R6: shadow only
      if (!lt) begin sh_en[ls][lp] = (ldv >> 1) & 1; sh_sel[ls][lp] = ldv & 1; end
      else sh_map[lp][ls] = ldv & 1;
    end
    slotm = (s == SLOTS - 1) ? 0 : s + 1;
    @(posedge clk); #1;
    for (int o = 0; o < 2; o++) begin
      if (!e_en[s][o]) check8("R4 disabled output", dout[o*DW +: DW], exp_o[o]);
      else if (e_en[s][1-o] && e_sel[s][0] == e_sel[s][1])
        check8("R7 multicast", dout[o*DW +: DW], exp_o[o]);
      else check8("R2/R3 routed sample", dout[o*DW +: DW], exp_o[o]);
    end
    check8("R5 frame mark", {7'd0, out_frm}, {7'd0, f});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; frm_i = 1'b0; din = '0; ld_en = 1'b0; ld_tgt = 1'b0;
    ld_slot = '0; ld_port = '0; ld_data = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check8("R1 reset outputs", dout[7:0] | dout[15:8], 8'h00);
    check8("R1 reset frame mark", {7'd0, out_frm}, 8'h00);
    for (int k = 0; k < 4; k++) cyc(k % 2 == 0, 0, 0, 0, 0, 0);  // R1: nothing loaded

    // exhaustive sweep: every crossbar setting against every read map
    for (int cfg = 0; cfg < 256; cfg++)
      for (int mp = 0; mp < 16; mp++) begin
        int c = 0;
        for (int k = 0; k < 4; k++) begin
          cyc(c % 2 == 0, 1, 0, k / 2, k % 2, (cfg >> (2 * k)) & 3); c++;
        end
        for (int k = 0; k < 4; k++) begin
          cyc(c % 2 == 0, 1, 1, k % 2, k / 2, (mp >> k) & 1); c++;
        end
        for (int k = 0; k < 4; k++) begin cyc(c % 2 == 0, 0, 0, 0, 0, 0); c++; end
      end

    // R8: irregular strobes with random loads
    for (int k = 0; k < 400; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      cyc(((lcg >> 8) & 3) == 0, (lcg >> 11) & 1, (lcg >> 12) & 1,
          (lcg >> 13) & 1, (lcg >> 14) & 1, (lcg >> 15) & 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule